// File: doc/BRIEF.md
# Trace Channel Write Capture Unit

This unit is the write side of an on-chip trace source. Processors store 1, 2, 4 or 8 bytes into per-channel address slots. Each store becomes one entry in a transmit queue. The entry carries the channel number, the payload right-aligned, a size code, a flag saying whether the store was timestamped, and the value of a free-running timestamp counter. A downstream serialiser, which is not part of this block, drains the queue through a valid/ready pop port.

Every channel owns a 16-byte slot made of two 8-byte windows. Stores to the lower window carry no timestamp. Stores to the upper window are timestamped and close a message. A small register file holds the following:
- one enable bit per trace source;
- one queue-full policy bit per trace source;
- the output clock divider code;
- a sticky overflow flag;
- read-only identification bytes.

A source in lossless policy is stalled through `wr_ready` while the queue is full. A source in lossy policy has its entry discarded instead, and the overflow flag is raised. The timestamp counter advances once per clock, so a 50 MHz capture clock gives 20 ns per count.

Top module: `trc_capture`

## Requirements
- R1: The store address selects a channel and a window. Bits [CH_W+3:4] give the channel, and bit 3 selects the window: 0 means no timestamp, 1 means timestamped. The entry reports these as `out_chan` and `out_stamp`.
- R2: The byte strobes select the access. Only naturally aligned patterns are accepted: one byte on any lane, 2 bytes starting at an even lane, 4 bytes starting at lane 0 or 4, or all 8 lanes. The size code is 0, 1, 2 or 3 for 1, 2, 4 or 8 bytes, and the payload is shifted down to bit 0 with the unused upper bits zero. Any other pattern, including all-zero, is accepted with `wr_ready` high and creates no entry.
- R3: The timestamp counter is 0 during reset and increases by 1 on each clock afterwards. An entry records the counter value of the cycle in which its store is accepted.
- R4: The source-enable register at offset 0x010 holds bit i for source i and resets to 0. A store from a disabled source is accepted with `wr_ready` high and creates no entry.
- R5: Mode bit i = 0 gives source i lossless behaviour. Its store to a full queue holds `wr_ready` low. The store is taken in the cycle after an entry leaves the queue.
- R6: The mode register at offset 0x008 resets to all ones, which is lossy. A lossy store to a full queue is accepted and discarded, and `ovf_flag` is set. The flag reads as bit 0 of the control register at offset 0x000. Writing 1 to that bit clears the flag, but a new drop in the same cycle keeps it set.
- R7: Control register bits 8:6 hold the divider code, which resets to 3. `div_ratio` equals 2*(code+1), giving ratios from 2 to 16.
- R8: The identification bytes sit at offsets 0xFC0 + 8*k for k = 0..7. Bytes k=0..3 assemble little-endian to 0x00080DEC, and bytes k=4..7 assemble to 0xB105F00D. Reads of unmapped offsets return 0.
- R9: The queue holds FIFO_DEPTH entries and returns them in arrival order. `out_valid` is high whenever the queue is not empty, and an entry leaves when `out_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Trace store request |
| wr_ready | output | 1 | Store accepted this cycle when high with wr_valid |
| wr_addr | input | CH_W+4 | Byte address inside the channel slot area |
| wr_src | input | SRC_W | Source number of the store |
| wr_strb | input | 8 | Byte-lane strobes |
| wr_data | input | 64 | Store data, lane-positioned |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| div_ratio | output | 5 | Output clock divide ratio |
| ovf_flag | output | 1 | Sticky drop indication |
| out_valid | output | 1 | Queue head is valid |
| out_ready | input | 1 | Pop the queue head |
| out_chan | output | CH_W | Channel of the head entry |
| out_stamp | output | 1 | Head entry came from the timestamped window |
| out_size | output | 2 | Size code of the head entry |
| out_data | output | 64 | Right-aligned payload of the head entry |
| out_time | output | TS_W | Timestamp of the head entry |

## Verification
The bench builds the unit with 8 channels, 4 sources, a 4-entry queue and a 16-bit timestamp. With this configuration every one of the 256 strobe patterns can be swept, together with every channel and window combination, in a few thousand cycles. The queue fills after four stores, so both full-queue policies can be reached in a few cycles: the lossless stall with its release edge, and the lossy drop with its sticky flag and write-one-to-clear. Expected sizes, lane offsets, payloads and timestamps come from the bench's own bit counting and cycle counting.

// File: rtl/trc_pkg.sv
package trc_pkg;

  typedef struct packed {
    logic       ok;
    logic [1:0] szc;
    logic [2:0] lane;
  } strb_info_t;

  localparam logic [31:0] PERIPH_ID = 32'h0008_0DEC;
  localparam logic [31:0] CELL_ID   = 32'hB105_F00D;
  localparam logic [11:0] CTRL_OFS  = 12'h000;
  localparam logic [11:0] MODE_OFS  = 12'h008;
  localparam logic [11:0] EN_OFS    = 12'h010;
  localparam int          DIV_LSB   = 6;
  localparam logic [2:0]  DIV_RESET = 3'd3;

  // Legal strobe = contiguous run of 2^z lanes starting on a multiple of 2^z.
  function automatic strb_info_t strb_decode(input logic [7:0] s);
    strb_info_t r;
    int w;
    r = '0;
    for (int z = 0; z < 4; z++) begin
      w = 1 << z;
      for (int l = 0; l < 8; l++) begin
        if ((l % w) == 0 && s == 8'(((1 << w) - 1) << l)) begin
          r.ok   = 1'b1;
          r.szc  = 2'(z);
          r.lane = 3'(l);
        end
      end
    end
    return r;
  endfunction

  function automatic logic [63:0] payload_align(input logic [63:0] d,
                                                input logic [2:0] lane,
                                                input logic [1:0] szc);
    logic [63:0] sh;
    sh = d >> {lane, 3'b000};
    case (szc)
      2'd0:    sh = {56'b0, sh[7:0]};
      2'd1:    sh = {48'b0, sh[15:0]};
      2'd2:    sh = {32'b0, sh[31:0]};
      default: sh = sh;
    endcase
    return sh;
  endfunction

  function automatic logic [4:0] div_ratio_of(input logic [2:0] c);
    return {1'b0, c, 1'b0} + 5'd2;
  endfunction

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    logic [63:0] both;
    both = {CELL_ID, PERIPH_ID};
    return both[{idx, 3'b000} +: 8];
  endfunction

endpackage

// File: rtl/trc_cfg_regs.sv
module trc_cfg_regs
  import trc_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [11:0]      addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic [N_SRC-1:0] mode_q,
  output logic [N_SRC-1:0] en_q,
  output logic [2:0]       div_code,
  input  logic             ovf_set,
  output logic             ovf_q
);

  logic ovf_clr;
  assign ovf_clr = we && addr == CTRL_OFS && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '1;
      en_q     <= '0;
      div_code <= DIV_RESET;
      ovf_q    <= 1'b0;
    end else begin
      if (we && addr == MODE_OFS) mode_q   <= wdata[N_SRC-1:0];
      if (we && addr == EN_OFS)   en_q     <= wdata[N_SRC-1:0];
      if (we && addr == CTRL_OFS) div_code <= wdata[DIV_LSB +: 3];
      if (ovf_set)      ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr[11:6] == 6'h3F && addr[2:0] == 3'b000)
      rdata = {24'b0, id_byte(addr[5:3])};
    else if (addr == CTRL_OFS)
      rdata = {23'b0, div_code, 5'b0, ovf_q};
    else if (addr == MODE_OFS)
      rdata = 32'(mode_q);
    else if (addr == EN_OFS)
      rdata = 32'(en_q);
  end

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q && !ovf_clr |=> ovf_q);
  // R6
  ovf_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |=> ovf_q);

endmodule

// File: rtl/trc_fifo.sv
module trc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 256
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  output logic                         full,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   count
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  assign full  = count == CNT_W'(DEPTH);
  assign empty = count == '0;
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  // R5
  push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full));
  // R9
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop && empty));

endmodule

// File: rtl/trc_capture.sv
module trc_capture
  import trc_pkg::*;
#(
  parameter int N_CHAN     = 256,
  parameter int N_SRC      = 32,
  parameter int FIFO_DEPTH = 256,
  parameter int TS_W       = 32,
  localparam int CH_W      = $clog2(N_CHAN),
  localparam int SRC_W     = $clog2(N_SRC),
  localparam int AW        = CH_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [AW-1:0]     wr_addr,
  input  logic [SRC_W-1:0]  wr_src,
  input  logic [7:0]        wr_strb,
  input  logic [63:0]       wr_data,
  input  logic              reg_we,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [4:0]        div_ratio,
  output logic              ovf_flag,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CH_W-1:0]   out_chan,
  output logic              out_stamp,
  output logic [1:0]        out_size,
  output logic [63:0]       out_data,
  output logic [TS_W-1:0]   out_time
);

  localparam int ENT_W = CH_W + 1 + 2 + 64 + TS_W;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic [N_SRC-1:0] mode_q, en_q;
  logic [2:0]       div_code;
  logic [TS_W-1:0]  ts_q;
  strb_info_t       sinfo;
  logic             src_en, src_lossy, take, push, drop, stall;
  logic             q_full, q_empty, q_pop;
  logic [CNT_W-1:0] q_count;
  logic [ENT_W-1:0] q_din, q_dout;

  trc_cfg_regs #(.N_SRC(N_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .mode_q(mode_q), .en_q(en_q), .div_code(div_code),
    .ovf_set(drop), .ovf_q(ovf_flag));

  always_ff @(posedge clk) begin
    if (!rst_n) ts_q <= '0;
    else        ts_q <= ts_q + 1'b1;
  end

  assign sinfo     = strb_decode(wr_strb);
  assign src_en    = en_q[wr_src];
  assign src_lossy = mode_q[wr_src];
  assign take      = wr_valid && sinfo.ok && src_en;
  assign push      = take && !q_full;
  assign drop      = take && q_full && src_lossy;
  assign stall     = take && q_full && !src_lossy;
  assign wr_ready  = !stall;
  assign div_ratio = div_ratio_of(div_code);

  assign q_din = {wr_addr[AW-1:4], wr_addr[3], sinfo.szc,
                  payload_align(wr_data, sinfo.lane, sinfo.szc), ts_q};

  trc_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(q_din), .full(q_full),
    .pop(q_pop), .dout(q_dout), .empty(q_empty), .count(q_count));

  assign out_valid = !q_empty;
  assign q_pop     = out_valid && out_ready;
  assign {out_chan, out_stamp, out_size, out_data, out_time} = q_dout;

  // R5
  stall_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> q_count == CNT_W'(FIFO_DEPTH));
  // R4
  disabled_no_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !src_en && !q_pop |=> $stable(q_count));
  // R6
  drop_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && q_full && sinfo.ok && src_en |=> ovf_flag);
  // R3
  ts_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ts_q == $past(ts_q) + 1'b1);

endmodule

// File: tb/tb_trc_capture.sv
module tb_trc_capture;
  localparam int P = 10;
  localparam int NC = 8, NS = 4, FD = 4, TW = 16;
  localparam int CW = 3, SW = 2, AW = 7;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, out_ready = 0, reg_we = 0;
  logic wr_ready, ovf_flag, out_valid, out_stamp;
  logic [AW-1:0] wr_addr = '0;
  logic [SW-1:0] wr_src = '0;
  logic [7:0] wr_strb = '0;
  logic [63:0] wr_data = '0, out_data;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [4:0] div_ratio;
  logic [CW-1:0] out_chan;
  logic [1:0] out_size;
  logic [TW-1:0] out_time;

  int n_vec = 0, n_bad = 0, cyc = 0, wd = 0;

  trc_capture #(.N_CHAN(NC), .N_SRC(NS), .FIFO_DEPTH(FD), .TS_W(TW)) dut (.*);

  always #(P/2) clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 100000) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp<100000", wd);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  // Bench restatement of the strobe rule: popcount power of two, contiguous, aligned.
  task automatic exp_strb(input logic [7:0] s, output bit ok, output int cnt, output int lo);
    cnt = $countones(s);
    lo = 0;
    for (int b = 7; b >= 0; b--) if (s[b]) lo = b;
    ok = (cnt == 1 || cnt == 2 || cnt == 4 || cnt == 8) &&
         (s == 8'(((1 << cnt) - 1) << lo)) && (lo % cnt == 0);
  endtask

  function automatic logic [63:0] exp_payload(input logic [63:0] d, input int cnt, input int lo);
    logic [63:0] v;
    v = d >> (lo * 8);
    if (cnt < 8) v = v & ((64'd1 << (cnt * 8)) - 1);
    return v;
  endfunction

  task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic reg_rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic bus_wr(input int src, input int ch, input int win, input logic [7:0] s,
                        input logic [63:0] d, output int t);
    wr_valid = 1; wr_src = SW'(src); wr_addr = AW'(ch * 16 + win * 8 + 3);
    wr_strb = s; wr_data = d;
    #1;
    while (!wr_ready) begin @(negedge clk); #1; end
    t = cyc;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic pop_chk(input string rq, input int ch, input int win, input int szc,
                         input logic [63:0] d, input int t);
    chk({rq, " valid"}, 64'(out_valid), 64'd1);
    chk({rq, " chan"}, 64'(out_chan), 64'(ch));
    chk({rq, " stamp"}, 64'(out_stamp), 64'(win));
    chk({rq, " size"}, 64'(out_size), 64'(szc));
    chk({rq, " data"}, out_data, d);
    chk({rq, " time"}, 64'(out_time), 64'(TW'(t)));
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
  endtask

  initial begin
    logic [31:0] r, pid, cid;
    int t, held_t;
    bit ok;
    int cnt, lo, szc;
    logic [63:0] d;
    int ts[FD];

    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // reset state
    chk("R9 reset empty", 64'(out_valid), 64'd0);
    chk("R7 reset ratio", 64'(div_ratio), 64'd8);
    chk("R6 reset ovf", 64'(ovf_flag), 64'd0);
    chk("R5 reset ready", 64'(wr_ready), 64'd1);
    reg_rd(12'h000, r); chk("R7 reset ctrl", 64'(r), 64'h0C0);
    reg_rd(12'h008, r); chk("R6 reset mode", 64'(r), 64'hF);
    reg_rd(12'h010, r); chk("R4 reset enable", 64'(r), 64'h0);

    // R8 identification bytes and an unmapped offset
    pid = '0; cid = '0;
    for (int k = 0; k < 4; k++) begin
      reg_rd(12'(12'hFC0 + 8 * k), r); pid = pid | (r << (8 * k));
      reg_rd(12'(12'hFE0 + 8 * k), r); cid = cid | (r << (8 * k));
    end
    chk("R8 periph id", 64'(pid), 64'h0008_0DEC);
    chk("R8 cell id", 64'(cid), 64'hB105_F00D);
    reg_rd(12'h018, r); chk("R8 unmapped", 64'(r), 64'h0);
    @(negedge clk);

    // R4 disabled at reset: store leaves no entry
    bus_wr(0, 1, 0, 8'hFF, 64'h1, t);
    #1; chk("R4 disabled src no entry", 64'(out_valid), 64'd0);
    @(negedge clk);

    // R7 all divider codes
    for (int c = 0; c < 8; c++) begin
      reg_wr(12'h000, 32'(c) << 6);
      #1; chk("R7 div ratio", 64'(div_ratio), 64'(2 * c + 2));
      reg_rd(12'h000, r); chk("R7 div field", 64'(r[8:6]), 64'(c));
      @(negedge clk);
    end

    // R2 R1 R3 sweep of all strobe patterns
    reg_wr(12'h010, 32'hF);
    for (int s = 0; s < 256; s++) begin
      d = {8{8'(s)}} ^ 64'h0123_4567_89AB_CDEF;
      exp_strb(8'(s), ok, cnt, lo);
      bus_wr(s % 4, s % 8, (s >> 3) & 1, 8'(s), d, t);
      #1;
      if (ok) begin
        szc = (cnt == 1) ? 0 : (cnt == 2) ? 1 : (cnt == 4) ? 2 : 3;
        pop_chk("R2 R1 R3 sweep", s % 8, (s >> 3) & 1, szc, exp_payload(d, cnt, lo), t);
      end else begin
        chk("R2 illegal strobe no entry", 64'(out_valid), 64'd0);
        @(negedge clk);
      end
    end

    // R1 every channel and window
    for (int ch = 0; ch < NC; ch++)
      for (int w = 0; w < 2; w++) begin
        d = 64'(ch * 1000 + w);
        bus_wr(ch % 4, ch, w, 8'hFF, d, t);
        #1; pop_chk("R1 chan/window", ch, w, 3, d, t);
      end

    // R4 selective enable
    reg_wr(12'h010, 32'h5);
    bus_wr(1, 2, 0, 8'h01, 64'h55, t);
    #1; chk("R4 src1 disabled", 64'(out_valid), 64'd0);
    @(negedge clk);
    bus_wr(2, 2, 1, 8'h01, 64'h66, t);
    #1; pop_chk("R4 src2 enabled", 2, 1, 0, 64'h66, t);
    reg_wr(12'h010, 32'hF);

    // R6 lossy drop on full queue, R9 order
    for (int i = 0; i < FD; i++) begin
      bus_wr(2, i, 0, 8'h0F, 64'(100 + i), t); ts[i] = t;
    end
    bus_wr(2, 7, 1, 8'h0F, 64'd999, t);
    #1;
    chk("R6 ovf after drop", 64'(ovf_flag), 64'd1);
    reg_rd(12'h000, r); chk("R6 ovf in ctrl", 64'(r[0]), 64'd1);
    for (int i = 0; i < FD; i++) pop_chk("R9 order after drop", i, 0, 2, 64'(100 + i), ts[i]);
    #1; chk("R6 dropped entry absent", 64'(out_valid), 64'd0);
    chk("R6 ovf sticky", 64'(ovf_flag), 64'd1);
    @(negedge clk);
    reg_wr(12'h000, 32'h0C1);
    #1; chk("R6 ovf cleared", 64'(ovf_flag), 64'd0);
    @(negedge clk);

    // R5 lossless stall and release
    reg_wr(12'h008, 32'hE);
    for (int i = 0; i < FD; i++) begin
      bus_wr(1, i + 4, 1, 8'hC0, 64'(i) << 48, t); ts[i] = t;
    end
    wr_valid = 1; wr_src = 0; wr_addr = AW'(3 * 16); wr_strb = 8'h30; wr_data = 64'hABCD << 32;
    for (int k = 0; k < 3; k++) begin
      #1; chk("R5 stalled while full", 64'(wr_ready), 64'd0);
      @(negedge clk);
    end
    out_ready = 1;
    #1; chk("R5 still stalled on pop cycle", 64'(wr_ready), 64'd0);
    chk("R5 head before release", 64'(out_chan), 64'd4);
    @(negedge clk);
    out_ready = 0;
    #1; chk("R5 released", 64'(wr_ready), 64'd1);
    held_t = cyc;
    @(negedge clk);
    wr_valid = 0;
    chk("R6 lossless no ovf", 64'(ovf_flag), 64'd0);
    for (int i = 1; i < FD; i++) pop_chk("R5 remaining", i + 4, 1, 1, 64'(i), ts[i]);
    #1; pop_chk("R5 held store", 3, 0, 1, 64'hABCD, held_t);
    #1; chk("R9 drained", 64'(out_valid), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule